// File: doc/BRIEF.md
# ADC Scan Sequencer

This block is the SPI master for an external multichannel successive-approximation converter with a bank of 4 or 8 inputs, chosen by the `NCH` parameter. A one-cycle pulse on `trig` starts a scan. The scan covers every channel whose bit is set in `en_mask`. For each of those channels the block sends a 32-bit channel-select command. It then raises chip select and sends a 32-bit no-operation command. The converter returns the result of the selected channel during that second frame. The low 16 bits it shifts back are emitted as one sample, tagged with the channel index and with a flag that marks the final sample of the scan.

The same shifter also sends two other frames. One is a 32-bit reset command, issued once on its own after power-up and again whenever the host asks for it. The other is a 24-bit register write that sets the input range of one channel. `busy` is high whenever a frame or an inter-frame gap is in progress. A trigger that arrives while the block is busy is dropped, and it raises a sticky overrun flag.

Top module: `adc_scan_seq`

## Requirements
- R1: The serial clock is low whenever chip select is high. The block changes MOSI on the rising clock edge and samples MISO on the falling edge, so each bit is launched on a rise and captured on the next fall.
- R2: A command frame is 32 bits long and is sent MSB first. Bits 31:24 carry the command code and bits 23:0 are zero.
- R3: For each channel it reads, the block sends a select frame with code 0xC0 + 4*channel. It then raises chip select and sends a no-operation frame with code 0x00. The sample data equals the last 16 bits received during the no-operation frame.
- R4: A scan visits the enabled channels in ascending index order and skips the disabled ones, so enabled results come out back to back. `smp_last` is 1 only on the sample of the highest enabled channel.
- R5: After reset is released, the block sends exactly one reset command frame (code 0x85) without being asked. `busy` is high from reset until that frame and its gap are complete. During reset `spi_cs_n` is 1, `spi_sclk` is 0 and `ovr` is 0.
- R6: A `rst_req` pulse while idle sends one reset command frame (code 0x85).
- R7: A `rng_req` pulse while idle with a valid code sends a 24-bit frame, MSB first. Bits 23:17 hold the address 5 + `rng_ch`, bit 16 is 1, bits 15:8 hold `rng_code` zero-extended, and bits 7:0 are 0. The valid codes are 0, 1, 2, 5 and 6.
- R8: A `rng_req` while idle with any other code sends no frame. It pulses `rng_err` high for one cycle, in the cycle after the request.
- R9: Between any two frames, chip select stays high for at least `CS_GAP` clock cycles (`CS_GAP` >= 2).
- R10: A `trig` while `busy` is high is ignored, and `ovr` is set one cycle later. `ovr` stays set until `ovr_clr` is asserted. A new set in the same cycle as a clear wins.
- R11: While idle, a `trig` with an all-zero mask starts nothing. `rst_req` and `rng_req` are ignored while busy. If several requests arrive together while idle, `rst_req` is served first, then `rng_req`, then `trig`, and the others are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig | input | 1 | Scan start pulse |
| en_mask | input | NCH | Channel enable mask, latched at trigger |
| rst_req | input | 1 | Request a reset command frame |
| rng_req | input | 1 | Request a range register write |
| rng_ch | input | $clog2(NCH) | Channel for range write |
| rng_code | input | 4 | Range code to write |
| ovr_clr | input | 1 | Clear the overrun flag |
| spi_miso | input | 1 | Serial data from converter |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to converter |
| smp_valid | output | 1 | Sample strobe |
| smp_ch | output | $clog2(NCH) | Channel of sample |
| smp_data | output | 16 | Conversion result |
| smp_last | output | 1 | Final sample of scan |
| busy | output | 1 | Operation in progress |
| ovr | output | 1 | Sticky overrun flag |
| rng_err | output | 1 | Invalid range code pulse |

## Verification
A sample appears one clock after the final half-period of its no-operation frame, when chip select has just risen. `rng_err` and `ovr` each follow their request by one clock. The bench drives all inputs on the falling clock edge and samples each flag on the next falling edge, which lands exactly one register stage later. A bus-level slave model decodes every frame at the rise of chip select and compares it against a queue of expected frames in order, so a missing, extra or misordered frame is reported wherever it occurs. Samples are popped from a second queue as they appear, so their timing never relies on a fixed cycle count.

// File: rtl/adc_scan_seq.sv
module adc_scan_seq #(
  parameter int NCH     = 8,
  parameter int CLK_DIV = 2,
  parameter int CS_GAP  = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   trig,
  input  logic [NCH-1:0]         en_mask,
  input  logic                   rst_req,
  input  logic                   rng_req,
  input  logic [$clog2(NCH)-1:0] rng_ch,
  input  logic [3:0]             rng_code,
  input  logic                   ovr_clr,
  input  logic                   spi_miso,
  output logic                   spi_sclk,
  output logic                   spi_cs_n,
  output logic                   spi_mosi,
  output logic                   smp_valid,
  output logic [$clog2(NCH)-1:0] smp_ch,
  output logic [15:0]            smp_data,
  output logic                   smp_last,
  output logic                   busy,
  output logic                   ovr,
  output logic                   rng_err
);
  localparam int CHW = $clog2(NCH);
  localparam int DW  = $clog2(CLK_DIV) + 1;
  localparam int GW  = $clog2(CS_GAP) + 1;
  localparam logic [31:0] RST_WORD = 32'h8500_0000;

  typedef enum logic [1:0] {S_IDLE, S_XFER, S_GAP} st_t;
  typedef enum logic [2:0] {P_BOOT, P_RST, P_RNG, P_SEL, P_NOP} ph_t;

  st_t st;
  ph_t ph, ld_ph;
  logic [31:0]    tx_sr, ld_word;
  logic [15:0]    rx_sr;
  logic [6:0]     hp, hp_end;
  logic [DW-1:0]  div;
  logic [GW-1:0]  gap;
  logic [CHW-1:0] cur, ld_ch;
  logic [NCH-1:0] mask, upper;
  logic [CHW:0]   first, nxt;
  logic           ld, ld_len24, err, code_ok, tick;

  function automatic logic [CHW:0] lowest(input logic [NCH-1:0] m);
    lowest = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (m[i]) lowest = {1'b1, CHW'(i)};
  endfunction

  function automatic logic [31:0] sel_word(input logic [CHW-1:0] c);
    sel_word = {8'hC0 | 8'({c, 2'b00}), 24'h0};
  endfunction

  always_comb
    for (int i = 0; i < NCH; i++) upper[i] = mask[i] && (i > int'(cur));

  assign first   = lowest(en_mask);
  assign nxt     = lowest(upper);
  assign code_ok = rng_code inside {4'd0, 4'd1, 4'd2, 4'd5, 4'd6};
  assign tick    = (div == DW'(CLK_DIV - 1));
  assign busy    = (st != S_IDLE);

  always_comb begin
    ld = 1'b0; ld_word = '0; ld_len24 = 1'b0; ld_ph = P_SEL; ld_ch = cur; err = 1'b0;
    if (st == S_IDLE) begin
      if (rst_req) begin
        ld = 1'b1; ld_word = RST_WORD; ld_ph = P_RST;
      end else if (rng_req) begin
        if (code_ok) begin
          ld = 1'b1; ld_len24 = 1'b1; ld_ph = P_RNG;
          ld_word = {7'd5 + 7'(rng_ch), 1'b1, 4'h0, rng_code, 16'h0};
        end else err = 1'b1;
      end else if (trig && first[CHW]) begin
        ld = 1'b1; ld_ch = first[CHW-1:0]; ld_word = sel_word(first[CHW-1:0]);
      end
    end else if (st == S_GAP && gap == '0) begin
      case (ph)
        P_BOOT: begin ld = 1'b1; ld_word = RST_WORD; ld_ph = P_RST; end
        P_SEL:  begin ld = 1'b1; ld_ph = P_NOP; end
        P_NOP:  if (nxt[CHW]) begin
                  ld = 1'b1; ld_ch = nxt[CHW-1:0]; ld_word = sel_word(nxt[CHW-1:0]);
                end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_GAP; ph <= P_BOOT; gap <= GW'(CS_GAP - 1);
      spi_cs_n <= 1'b1; spi_sclk <= 1'b0; spi_mosi <= 1'b0;
      div <= '0; hp <= '0; hp_end <= 7'd64; tx_sr <= '0; rx_sr <= '0;
      cur <= '0; mask <= '0; ovr <= 1'b0; rng_err <= 1'b0;
      smp_valid <= 1'b0; smp_ch <= '0; smp_data <= '0; smp_last <= 1'b0;
    end else begin
      smp_valid <= 1'b0;
      rng_err   <= err;
      if (ovr_clr) ovr <= 1'b0;
      if (trig && busy) ovr <= 1'b1;
      if (ld) begin
        st <= S_XFER; spi_cs_n <= 1'b0; div <= '0; hp <= '0;
        tx_sr <= ld_word; hp_end <= ld_len24 ? 7'd48 : 7'd64;
        ph <= ld_ph; cur <= ld_ch;
        if (st == S_IDLE) mask <= en_mask;
      end else begin
        case (st)
          S_GAP: if (gap == '0) st <= S_IDLE; else gap <= gap - 1'b1;
          S_XFER:
            if (!tick) div <= div + 1'b1;
            else begin
              div <= '0;
              hp  <= hp + 1'b1;
              if (hp == hp_end) begin
                st <= S_GAP; spi_cs_n <= 1'b1; gap <= GW'(CS_GAP - 1);
                if (ph == P_NOP) begin
                  smp_valid <= 1'b1; smp_ch <= cur;
                  smp_data  <= rx_sr; smp_last <= !nxt[CHW];
                end
              end else if (!hp[0]) begin
                spi_sclk <= 1'b1; spi_mosi <= tx_sr[31]; tx_sr <= tx_sr << 1;
              end else begin
                spi_sclk <= 1'b0; rx_sr <= {rx_sr[14:0], spi_miso};
              end
            end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk #(
  parameter int CS_GAP = 3
) (
  input logic clk,
  input logic rst_n,
  input logic spi_cs_n,
  input logic spi_sclk,
  input logic busy,
  input logic trig,
  input logic ovr,
  input logic ovr_clr,
  input logic rng_err,
  input logic smp_valid
);
  logic [15:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) hi_cnt <= '0;
    else if (!spi_cs_n) hi_cnt <= '0;
    else if (hi_cnt != 16'hFFFF) hi_cnt <= hi_cnt + 1'b1;

  AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (!rst_n) spi_cs_n |-> !spi_sclk); // R1
  AST_CS_GAP:    assert property (@(posedge clk) disable iff (!rst_n) $fell(spi_cs_n) |-> int'(hi_cnt) >= CS_GAP); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> spi_cs_n); // R11
  AST_OVR_SET:   assert property (@(posedge clk) disable iff (!rst_n) trig && busy |=> ovr); // R10
  AST_OVR_HOLD:  assert property (@(posedge clk) disable iff (!rst_n) ovr && !ovr_clr |=> ovr); // R10
  AST_RNG_ERR:   assert property (@(posedge clk) disable iff (!rst_n) rng_err |-> spi_cs_n && !busy); // R8
  AST_SMP_AFTER: assert property (@(posedge clk) disable iff (!rst_n) smp_valid |-> spi_cs_n); // R3
endmodule

bind adc_scan_seq adc_scan_seq_chk #(.CS_GAP(CS_GAP)) u_chk (
  .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .busy(busy),
  .trig(trig), .ovr(ovr), .ovr_clr(ovr_clr), .rng_err(rng_err), .smp_valid(smp_valid)
);

// File: tb/test_adc_scan_seq.sv
module test_adc_scan_seq;
  localparam int NCH = 8, CLK_DIV = 2, CS_GAP = 3, CHW = 3;

  logic clk = 0, rst_n = 0, trig = 0, rst_req = 0, rng_req = 0, ovr_clr = 0, spi_miso = 0;
  logic [NCH-1:0] en_mask = '0;
  logic [CHW-1:0] rng_ch = '0;
  logic [3:0] rng_code = '0;
  logic spi_sclk, spi_cs_n, spi_mosi, smp_valid, smp_last, busy, ovr, rng_err;
  logic [CHW-1:0] smp_ch;
  logic [15:0] smp_data;

  adc_scan_seq #(.NCH(NCH), .CLK_DIV(CLK_DIV), .CS_GAP(CS_GAP)) i_adc_scan_seq (
    .clk(clk), .rst_n(rst_n), .trig(trig), .en_mask(en_mask), .rst_req(rst_req),
    .rng_req(rng_req), .rng_ch(rng_ch), .rng_code(rng_code), .ovr_clr(ovr_clr),
    .spi_miso(spi_miso), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .smp_valid(smp_valid), .smp_ch(smp_ch), .smp_data(smp_data), .smp_last(smp_last),
    .busy(busy), .ovr(ovr), .rng_err(rng_err));

  always #10 clk = ~clk;

  int total = 0, bad = 0, errcnt = 0, hi_cnt = 0, hi_min = 1000;
  logic [37:0] fq[$];
  string ftag[$];
  logic [20:0] sq[$];
  logic [11:0] seed = 12'h000;
  logic [2:0] sel_ch = '0;
  logic [31:0] fr, msr;
  int nb;
  bit in_frame = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // converter model
  always @(negedge spi_cs_n) begin
    in_frame = 1; nb = 0; fr = '0; msr = {16'h0, 1'b0, sel_ch, seed};
  end
  always @(negedge spi_sclk) if (spi_cs_n === 1'b0) begin fr = {fr[30:0], spi_mosi}; nb++; end
  always @(posedge spi_sclk) if (spi_cs_n === 1'b0) begin spi_miso <= msr[31]; msr = msr << 1; end
  always @(posedge spi_cs_n) if (in_frame) begin
    in_frame = 0;
    chk(spi_sclk == 1'b0, "R1", "sclk at cs rise", 64'(spi_sclk), 0);
    if (fq.size() == 0) chk(0, "R11", "unexpected frame", {nb[5:0], fr}, 0);
    else begin
      logic [37:0] e;
      string t;
      e = fq.pop_front(); t = ftag.pop_front();
      chk({nb[5:0], fr} == e, t, "frame", {nb[5:0], fr}, e);
    end
    if (nb == 32 && fr[31:30] == 2'b11) sel_ch = fr[28:26];
  end

  // sample monitor, error-pulse and gap counters
  always @(negedge clk) if (rst_n) begin
    if (rng_err) errcnt++;
    if (spi_cs_n) hi_cnt++;
    else begin
      if (hi_cnt > 0 && hi_cnt < hi_min) hi_min = hi_cnt;
      hi_cnt = 0;
    end
    if (smp_valid) begin
      if (sq.size() == 0) chk(0, "R4", "unexpected sample", {smp_ch, smp_last, smp_data}, 0);
      else begin
        logic [20:0] e;
        e = sq.pop_front();
        chk({1'b0, smp_ch, smp_last, smp_data} == e, "R3", "sample ch/last/data",
            {1'b0, smp_ch, smp_last, smp_data}, e);
      end
    end
  end

  task automatic push_frame(input logic [5:0] n, input logic [31:0] v, input string t);
    fq.push_back({n, v}); ftag.push_back(t);
  endtask

  task automatic scan_exp(input logic [7:0] m, input logic [11:0] s);
    seed = s;
    for (int c = 0; c < NCH; c++) if (m[c]) begin
      push_frame(6'd32, {8'hC0 + 8'(c * 4), 24'h0}, "R3");
      push_frame(6'd32, 32'h0, "R2");
      sq.push_back({4'(c), ((m >> (c + 1)) == 0), 1'b0, 3'(c), s});
    end
  endtask

  task automatic wait_idle;
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic queues_empty(input string t);
    chk(fq.size() == 0, t, "frames outstanding", fq.size(), 0);
    chk(sq.size() == 0, t, "samples outstanding", sq.size(), 0);
  endtask

  task automatic scan(input logic [7:0] m, input logic [11:0] s);
    scan_exp(m, s);
    @(negedge clk); en_mask = m; trig = 1;
    @(negedge clk); trig = 0;
    wait_idle();
    queues_empty("R4");
  endtask

  task automatic range_wr(input logic [2:0] ch, input logic [3:0] code);
    push_frame(6'd24, {8'h0, 7'd5 + 7'(ch), 1'b1, 4'h0, code, 8'h00}, "R7");
    @(negedge clk); rng_ch = ch; rng_code = code; rng_req = 1;
    @(negedge clk); rng_req = 0;
    wait_idle();
    queues_empty("R7");
  endtask

  task automatic range_bad(input logic [3:0] code);
    int e0;
    e0 = errcnt;
    @(negedge clk); rng_ch = 3'd1; rng_code = code; rng_req = 1;
    @(negedge clk); rng_req = 0;
    chk(rng_err == 1'b1, "R8", "rng_err pulse", 64'(rng_err), 1);
    repeat (4) @(negedge clk);
    chk(busy == 1'b0 && spi_cs_n == 1'b1, "R8", "no frame on bad code", {busy, spi_cs_n}, 2'b01);
    chk(errcnt == e0 + 1, "R8", "single error pulse", errcnt, e0 + 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog run did not finish actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy && spi_cs_n && !spi_sclk && !ovr && !smp_valid, "R5", "reset state",
        {busy, spi_cs_n, spi_sclk, ovr, smp_valid}, 5'b11000);
    push_frame(6'd32, 32'h8500_0000, "R5");
    rst_n = 1;
    wait_idle();
    queues_empty("R5");

    scan(8'hFF, 12'h3A5);
    scan(8'hA6, 12'h0F1);
    scan(8'h80, 12'h777);
    scan(8'h01, 12'h5C3);

    // empty mask
    @(negedge clk); en_mask = 8'h00; trig = 1;
    @(negedge clk); trig = 0;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && spi_cs_n == 1'b1, "R11", "empty mask idle", {busy, spi_cs_n}, 2'b01);

    range_wr(3'd2, 4'd5);
    range_wr(3'd7, 4'd6);
    range_wr(3'd0, 4'd0);
    range_bad(4'd3);
    range_bad(4'd7);

    push_frame(6'd32, 32'h8500_0000, "R6");
    @(negedge clk); rst_req = 1;
    @(negedge clk); rst_req = 0;
    wait_idle();
    queues_empty("R6");

    // overrun and requests while busy
    scan_exp(8'h24, 12'h9E2);
    @(negedge clk); en_mask = 8'h24; trig = 1;
    @(negedge clk); trig = 0;
    repeat (20) @(negedge clk);
    trig = 1; en_mask = 8'hFF;
    @(negedge clk); trig = 0;
    chk(ovr == 1'b1, "R10", "overrun set", 64'(ovr), 1);
    rng_req = 1; rng_code = 4'd1; rst_req = 1;
    @(negedge clk); rng_req = 0; rst_req = 0;
    wait_idle();
    queues_empty("R11");
    chk(ovr == 1'b1, "R10", "overrun sticky", 64'(ovr), 1);
    ovr_clr = 1;
    @(negedge clk); ovr_clr = 0;
    chk(ovr == 1'b0, "R10", "overrun cleared", 64'(ovr), 0);

    // simultaneous requests while idle
    begin
      int e0;
      e0 = errcnt;
      push_frame(6'd32, 32'h8500_0000, "R11");
      @(negedge clk); rst_req = 1; rng_req = 1; rng_code = 4'd3; trig = 1; en_mask = 8'hFF;
      @(negedge clk); rst_req = 0; rng_req = 0; trig = 0;
      wait_idle();
      queues_empty("R11");
      chk(ovr == 1'b0 && errcnt == e0, "R11", "lower requests dropped", {ovr, errcnt[7:0]}, {1'b0, e0[7:0]});
    end

    scan(8'h5A, 12'hBEE);
    chk(hi_min >= CS_GAP, "R9", "min cs high cycles", hi_min, CS_GAP);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule